// File: doc/BRIEF.md
# Asynchronous Bus Memory Target

This block is a slave endpoint on a shared memory and I/O bus that moves data with a fully interlocked two-strobe handshake. A master places an 18-bit byte address, a 2-bit transfer code and, for writes, a 16-bit word on the bus, then raises its strobe. When the address falls inside the block's window, the block performs the access against a small word-addressed store and answers with its own acknowledge strobe. The delay before that answer is set by a parameter, so slow and fast targets can share one bus.

The acknowledge stays high until the master drops its strobe. The block then drops the acknowledge and releases the data lines. Each stored byte carries its own parity bit, and on reads the block drives both parity bits beside the data. An address outside the window gets no answer, so the master times out. A synchronous bus initialize input returns the handshake to idle and clears the store.

Top module: `abus_mem_target`

## Requirements
- R1: While `bus_init` is high and on the first cycle after it falls, `slv_ack`, `rdata_oe`, `rdata`, `par_lo` and `par_hi` are all 0. Every word of the store then reads back as 0x0000 with `par_lo`=1 and `par_hi`=1.
- R2: The block answers only when BASE <= `addr` < BASE + 2*WORDS. For any other address it never raises `slv_ack` or `rdata_oe` and leaves the store unchanged.
- R3: `slv_ack` first reads high after the (WAIT_CYC+1)-th rising edge that follows the edge at which a hit with `mst_sync` high is first sampled. It is low before that edge.
- R4: Once high, `slv_ack` stays high for as long as `mst_sync` is high. It is low one cycle after `mst_sync` is sampled low. `rdata_oe` falls in that same cycle.
- R5: `xfer`=00 is a read. From the cycle after the strobe is accepted until release, `rdata_oe`=1 and `rdata` holds the stored word at index (`addr`-BASE)>>1.
- R6: `xfer`=01 is a read with intent to modify. It returns the same data and parity as a plain read and does not change the store.
- R7: `xfer`=10 is a word write. It stores all 16 bits of `wdata`, ignores `addr` bit 0 and keeps `rdata_oe` low.
- R8: `xfer`=11 is a byte write. With `addr` bit 0 = 0 it stores `wdata[7:0]` in the low byte. With `addr` bit 0 = 1 it stores `wdata[15:8]` in the high byte. The other byte is left unchanged.
- R9: On reads, `par_lo` makes the number of ones in `rdata[7:0]` plus itself odd, and `par_hi` does the same for `rdata[15:8]`. Each write regenerates the parity of each byte it writes.
- R10: If `mst_sync` falls before `slv_ack` rises, the block returns to idle. It never raises `slv_ack` for that cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_init | input | 1 | Synchronous bus initialize, active high |
| mst_sync | input | 1 | Master strobe |
| addr | input | 18 | Byte address |
| xfer | input | 2 | Transfer code: 00 read, 01 read-modify, 10 word write, 11 byte write |
| wdata | input | 16 | Write data |
| slv_ack | output | 1 | Slave acknowledge strobe |
| rdata | output | 16 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Data and parity drive enable |
| par_lo | output | 1 | Odd parity bit of the low byte |
| par_hi | output | 1 | Odd parity bit of the high byte |

## Verification
The bench tests the edges of the window: the address one below the base, the first byte past the end, and the odd byte of the last word. A decode with an off-by-one error would answer outside the window or leave the last word unreachable. The bench counts the exact cycle in which the acknowledge appears, and it holds the strobe high long enough to catch an acknowledge that drops early or lingers after release. Byte writes to each half, followed by read-back of both data and parity, expose a lane swap or a parity bit that is not regenerated. An aborted strobe followed by a read-back shows a write that went through without its acknowledge.

// File: rtl/abus_pkg.sv
package abus_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    XF_READ      = 2'b00,
    XF_READ_HOLD = 2'b01,
    XF_WORD_WR   = 2'b10,
    XF_BYTE_WR   = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;

  // parity bit that makes a byte plus the bit hold an odd number of ones
  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction

  function automatic logic xfer_is_read(input logic [1:0] x);
    return ~x[1];
  endfunction

  // byte-lane enables for a write kind and address bit 0
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] x, input logic a0);
    if (x == XF_BYTE_WR) return a0 ? 2'b10 : 2'b01;
    return 2'b11;
  endfunction
endpackage

// File: rtl/abus_decode.sv
module abus_decode #(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] BASE = 18'h01000,
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(2 * WORDS);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE;
    hit    = (addr >= BASE) && ({1'b0, offset} < SPAN);
    idx    = offset[IDX_W:1];
  end
endmodule

// File: rtl/abus_store.sv
module abus_store
  import abus_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_par,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [DATA_W-1:0] wr_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W:0] cells [WORDS];
    logic [BYTE_W:0] old_cell;
    logic [BYTE_W-1:0] new_byte;

    assign new_byte = wr_data[g*BYTE_W +: BYTE_W];
    assign old_cell = cells[wr_idx];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < WORDS; i++) cells[i] <= {1'b1, {BYTE_W{1'b0}}};
      end else if (wr_en && wr_lane[g]) begin
        cells[wr_idx] <= {odd_par(new_byte), new_byte};
      end
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = cells[rd_idx][BYTE_W-1:0];
    assign rd_par[g] = cells[rd_idx][BYTE_W];

    assert_lane_parity_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_lane[g]) |=>
        (cells[$past(wr_idx)][BYTE_W] == ~^cells[$past(wr_idx)][BYTE_W-1:0]));

    assert_lane_kept_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_lane[g]) |=> (cells[$past(wr_idx)] == $past(old_cell)));
  end
endmodule

// File: rtl/abus_hshake.sv
module abus_hshake
  import abus_pkg::*;
#(
  parameter int WAIT_CYC = 3,
  localparam int CNT_W = $clog2(WAIT_CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic mst_sync,
  input  logic hit,
  input  logic wr_q,
  output logic capture,
  output logic commit,
  output logic active,
  output logic slv_ack
);
  hs_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             wait_done;

  assign capture   = (state == HS_IDLE) && mst_sync && hit;
  assign wait_done = (state == HS_WAIT) && mst_sync && (cnt == '0);
  assign commit    = wait_done && wr_q;
  assign active    = (state != HS_IDLE);
  assign slv_ack   = (state == HS_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HS_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        HS_IDLE: if (capture) begin
          state <= HS_WAIT;
          cnt   <= CNT_W'(WAIT_CYC);
        end
        HS_WAIT: begin
          if (!mst_sync)      state <= HS_IDLE;
          else if (wait_done) state <= HS_ACK;
          else                cnt   <= cnt - 1'b1;
        end
        HS_ACK: if (!mst_sync) state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WAIT_CYC));

  assert_ack_after_wait_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(slv_ack) |-> ($past(state) == HS_WAIT) && $past(mst_sync));

  assert_ack_held_R4: assert property (@(posedge clk) disable iff (rst)
    (slv_ack && mst_sync) |=> slv_ack);

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (rst)
    (slv_ack && !mst_sync) |=> !slv_ack);

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state == HS_WAIT && !mst_sync) |=> !active && !slv_ack);
endmodule

// File: rtl/abus_mem_target.sv
module abus_mem_target
  import abus_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] BASE = 18'h01000,
  parameter int WORDS = 64,
  parameter int WAIT_CYC = 3
) (
  input  logic              clk,
  input  logic              bus_init,
  input  logic              mst_sync,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        xfer,
  input  logic [15:0]       wdata,
  output logic              slv_ack,
  output logic [15:0]       rdata,
  output logic              rdata_oe,
  output logic              par_lo,
  output logic              par_hi
);
  localparam int IDX_W = $clog2(WORDS);

  logic              hit, capture, commit, active;
  logic [IDX_W-1:0]  idx, idx_q;
  logic [1:0]        xfer_q;
  logic              a0_q;
  logic [DATA_W-1:0] wdata_q, mem_data, rd_q;
  logic [LANES-1:0]  mem_par, par_q;

  abus_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_dec (
    .addr(addr), .hit(hit), .idx(idx)
  );

  abus_hshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
    .clk(clk), .rst(bus_init), .mst_sync(mst_sync), .hit(hit),
    .wr_q(xfer_q[1]), .capture(capture), .commit(commit),
    .active(active), .slv_ack(slv_ack)
  );

  abus_store #(.WORDS(WORDS)) u_mem (
    .clk(clk), .rst(bus_init),
    .rd_idx(idx), .rd_data(mem_data), .rd_par(mem_par),
    .wr_en(commit), .wr_idx(idx_q), .wr_lane(lane_mask(xfer_q, a0_q)),
    .wr_data(wdata_q)
  );

  always_ff @(posedge clk) begin
    if (bus_init) begin
      idx_q   <= '0;
      xfer_q  <= XF_READ;
      a0_q    <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
      par_q   <= '0;
    end else if (capture) begin
      idx_q   <= idx;
      xfer_q  <= xfer;
      a0_q    <= addr[0];
      wdata_q <= wdata;
      rd_q    <= mem_data;
      par_q   <= mem_par;
    end
  end

  assign rdata_oe = active && xfer_is_read(xfer_q);
  assign rdata    = rdata_oe ? rd_q : '0;
  assign par_lo   = rdata_oe & par_q[0];
  assign par_hi   = rdata_oe & par_q[1];

  assert_miss_no_capture_R2: assert property (@(posedge clk) disable iff (bus_init)
    (!active && !hit) |-> !capture);

  assert_release_together_R4: assert property (@(posedge clk) disable iff (bus_init)
    $fell(slv_ack) |-> !rdata_oe);

  assert_read_stable_R5: assert property (@(posedge clk) disable iff (bus_init)
    (rdata_oe && $past(rdata_oe)) |-> $stable(rdata) && $stable(par_lo) && $stable(par_hi));

  assert_write_no_drive_R7: assert property (@(posedge clk) disable iff (bus_init)
    commit |=> slv_ack && !rdata_oe);
endmodule

// File: tb/abus_mem_target_test.sv
module abus_mem_target_test;
  localparam int CLK_P    = 10;
  localparam logic [17:0] BASE = 18'h01000;
  localparam int WORDS    = 64;
  localparam int WAIT_CYC = 3;

  logic clk = 1'b0;
  logic bus_init = 1'b1;
  logic mst_sync = 1'b0;
  logic [17:0] addr = '0;
  logic [1:0]  xfer = 2'b00;
  logic [15:0] wdata = '0;
  logic slv_ack, rdata_oe, par_lo, par_hi;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [WORDS];

  always #(CLK_P/2) clk = ~clk;

  abus_mem_target #(.BASE(BASE), .WORDS(WORDS), .WAIT_CYC(WAIT_CYC)) uut (
    .clk(clk), .bus_init(bus_init), .mst_sync(mst_sync), .addr(addr),
    .xfer(xfer), .wdata(wdata), .slv_ack(slv_ack), .rdata(rdata),
    .rdata_oe(rdata_oe), .par_lo(par_lo), .par_hi(par_hi)
  );

  function automatic logic ref_par(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(b[i]);
    return (ones % 2) == 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one bus cycle; returns whether acknowledged, at which loop step, and the read values
  task automatic bus_cycle(input logic [1:0] xt, input logic [17:0] a, input logic [15:0] d,
                           output bit acked, output int lat, output logic [15:0] rd,
                           output logic pl, output logic ph, output bit oe_first);
    @(negedge clk);
    xfer = xt; addr = a; wdata = d; mst_sync = 1'b1;
    acked = 0; lat = -1; rd = '0; pl = 0; ph = 0; oe_first = 0;
    for (int k = 0; k < WAIT_CYC + 6; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 0) oe_first = rdata_oe;
      if (slv_ack) begin
        acked = 1; lat = k; rd = rdata; pl = par_lo; ph = par_hi;
        break;
      end
    end
    if (acked) begin
      repeat (2) begin
        @(posedge clk); @(negedge clk);
        check(slv_ack === 1'b1, "R4", "ack held while strobe high", slv_ack, 1);
      end
    end
    mst_sync = 1'b0;
    @(posedge clk); @(negedge clk);
    check(slv_ack === 1'b0 && rdata_oe === 1'b0, "R4", "release after strobe low",
          {slv_ack, rdata_oe}, 0);
  endtask

  task automatic read_expect(input string req, input logic [1:0] xt, input logic [17:0] a);
    bit acked, oe1; int lat; logic [15:0] rd; logic pl, ph;
    logic [15:0] exp;
    exp = model[(a - BASE) >> 1];
    bus_cycle(xt, a, 16'h0, acked, lat, rd, pl, ph, oe1);
    check(acked && lat == WAIT_CYC + 1, "R3", "ack latency", lat, WAIT_CYC + 1);
    check(oe1 == 1'b1, "R5", "drive starts after accept", oe1, 1);
    check(rd == exp, req, "read data", rd, exp);
    check(pl == ref_par(exp[7:0]) && ph == ref_par(exp[15:8]), "R9", "parity",
          {ph, pl}, {ref_par(exp[15:8]), ref_par(exp[7:0])});
  endtask

  task automatic write_do(input string req, input logic [1:0] xt,
                          input logic [17:0] a, input logic [15:0] d);
    bit acked, oe1; int lat; logic [15:0] rd; logic pl, ph;
    int w;
    bus_cycle(xt, a, d, acked, lat, rd, pl, ph, oe1);
    check(acked && lat == WAIT_CYC + 1, req, "write ack latency", lat, WAIT_CYC + 1);
    check(oe1 == 1'b0, "R7", "no drive on write", oe1, 0);
    w = int'((a - BASE) >> 1);
    if (xt == 2'b10) model[w] = d;
    else if (a[0]) model[w][15:8] = d[15:8];
    else model[w][7:0] = d[7:0];
  endtask

  task automatic t_reset;
    bus_init = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({slv_ack, rdata_oe, rdata, par_lo, par_hi} == '0, "R1", "outputs in init",
          {slv_ack, rdata_oe, rdata, par_lo, par_hi}, 0);
    bus_init = 1'b0;
    @(posedge clk); @(negedge clk);
    check({slv_ack, rdata_oe, rdata, par_lo, par_hi} == '0, "R1", "outputs after init",
          {slv_ack, rdata_oe, rdata, par_lo, par_hi}, 0);
    for (int i = 0; i < WORDS; i++) model[i] = 16'h0000;
    read_expect("R1", 2'b00, BASE + 18'd10);
  endtask

  task automatic t_window;
    bit acked, oe1, saw_oe; int lat; logic [15:0] rd; logic pl, ph;
    bus_cycle(2'b10, BASE - 18'd1, 16'hDEAD, acked, lat, rd, pl, ph, oe1);
    check(!acked, "R2", "below window no ack", acked, 0);
    bus_cycle(2'b00, BASE + 18'(2 * WORDS), 16'h0, acked, lat, rd, pl, ph, oe1);
    check(!acked && !oe1, "R2", "past window silent", {acked, oe1}, 0);
    write_do("R2", 2'b10, BASE + 18'(2 * WORDS - 1), 16'hA5C3);
    read_expect("R2", 2'b00, BASE + 18'(2 * WORDS - 2));
    saw_oe = 0;
    read_expect("R2", 2'b00, BASE);
    check(model[WORDS-1] == 16'hA5C3 && model[0] == 16'h0, "R2", "model sane", 0, 0);
  endtask

  task automatic t_word_and_pause;
    write_do("R7", 2'b10, BASE + 18'd5, 16'h1234);
    read_expect("R7", 2'b00, BASE + 18'd4);
    write_do("R7", 2'b10, BASE + 18'd20, 16'hFFFE);
    read_expect("R6", 2'b01, BASE + 18'd20);
    read_expect("R6", 2'b00, BASE + 18'd21);
  endtask

  task automatic t_byte;
    write_do("R8", 2'b10, BASE + 18'd40, 16'h0F0F);
    write_do("R8", 2'b11, BASE + 18'd40, 16'hAA77);
    read_expect("R8", 2'b00, BASE + 18'd40);
    check(model[20] == 16'h0F77, "R8", "model low lane", model[20], 16'h0F77);
    write_do("R8", 2'b11, BASE + 18'd41, 16'h8133);
    read_expect("R8", 2'b00, BASE + 18'd40);
    read_expect("R9", 2'b00, BASE + 18'd41);
  endtask

  task automatic t_abort;
    @(negedge clk);
    xfer = 2'b10; addr = BASE + 18'd60; wdata = 16'h5555; mst_sync = 1'b1;
    repeat (WAIT_CYC) @(posedge clk);
    @(negedge clk);
    check(slv_ack == 1'b0, "R3", "no early ack", slv_ack, 0);
    mst_sync = 1'b0;
    for (int k = 0; k < WAIT_CYC + 4; k++) begin
      @(posedge clk); @(negedge clk);
      check(slv_ack == 1'b0, "R10", "no ack after abort", slv_ack, 0);
    end
    read_expect("R10", 2'b00, BASE + 18'd60);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_window();
    t_word_and_pause();
    t_byte();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule